// File: doc/BRIEF.md
# Receive FIFO with Error-Tagged Entries

This block is the receive buffer of a UART. Each byte from the deserialiser is stored together with three error flags: parity, framing and break. The entry at the head of the queue is always visible on the outputs, with its data and flags, together with the fill level. The block also produces three status outputs: a flag that shows the fill level has reached a programmable trigger, a sticky overrun flag, and an aggregate error bit. All three are suitable for a line status register.

Errors are reported in queue order. The line-status interrupt only looks at the head entry, so an errored byte that is still deep in the queue stays silent until it reaches the head. A running count of errored entries keeps the aggregate error bit set while any such entry is stored. When the queue is disabled, the block holds a single byte, and the same status logic then applies to that one entry.

Top module: `rx_err_fifo`

## Requirements
- R1: After reset the level is 0, the head outputs are 0, and the aggregate error bit, the overrun flag and the interrupt are all low.
- R2: Bytes leave in the order they arrived. A push raises the level by one and a pop lowers it by one. A push and a pop in the same cycle leave the level unchanged. The head outputs show the oldest byte and its flags, with flag bit 0 = parity, bit 1 = framing and bit 2 = break. Both head outputs read 0 when the queue is empty.
- R3: When the queue is full (16 entries when enabled), a push without a pop is dropped and sets the overrun flag. A push with a pop in the same cycle is accepted. The overrun flag stays set until a line-status read.
- R4: The interrupt is high only when the interrupt enable is high and the head entry has at least one error flag set. An errored byte behind a clean head does not raise it.
- R5: A line-status read with no pop in the same cycle lowers the interrupt from the next cycle onward. It stays low while the same entry remains at the head.
- R6: The interrupt re-arms when a pop brings a new entry to the head, or when a byte is pushed into an empty queue.
- R7: The aggregate error bit is high whenever at least one stored entry has an error flag set. It falls in the cycle after the last such entry is popped.
- R8: The trigger flag is high when the level is at least the selected threshold. The select values 0, 1, 2 and 3 give thresholds of 1, 4, 8 and 14 entries.
- R9: With the queue disabled the block holds one byte. A second push is dropped and sets overrun, and the trigger flag means that the level is not 0.
- R10: A flush, or any change of the enable input, empties the queue and clears the aggregate error bit and the interrupt. It leaves the overrun flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = 16-entry queue, 0 = single holding byte |
| flush_i | input | 1 | Empty the queue |
| push_i | input | 1 | Received-byte strobe |
| push_data_i | input | 8 | Received byte |
| push_err_i | input | 3 | Error flags of the received byte {break, framing, parity} |
| pop_i | input | 1 | Remove the head entry |
| lsr_rd_i | input | 1 | Line status register read strobe |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| trig_sel_i | input | 2 | Trigger threshold select |
| head_data_o | output | 8 | Data of the head entry |
| head_err_o | output | 3 | Error flags of the head entry |
| level_o | output | 5 | Number of stored entries |
| trig_o | output | 1 | Level has reached the threshold |
| err_any_o | output | 1 | Some stored entry is errored |
| overrun_o | output | 1 | Sticky overrun flag |
| lsi_o | output | 1 | Line-status interrupt |

## Verification
The hardest state to reach is an interrupt that has been cleared by a line-status read while its errored entry is still at the head, and that must then re-arm only when a pop brings a different errored byte to the head. The stimulus table reaches this state in a fixed order. It pushes a clean byte followed by errored ones, reads the status register between pops, and pops across two errored entries in a row. It also pushes an errored byte into an empty queue and does a pop and push in the same cycle. The directed part fills the queue to exactly 16 entries before pushing once more. It also toggles the enable input while the overrun flag is set, which shows that a mode change flushes the queue but keeps the overrun flag.

// File: rtl/rx_err_fifo_pkg.sv
package rx_err_fifo_pkg;
  localparam int unsigned ERR_W = 3;
  localparam int unsigned ERR_PAR = 0;
  localparam int unsigned ERR_FRM = 1;
  localparam int unsigned ERR_BRK = 2;
  typedef logic [ERR_W-1:0] err_t;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ERR_W  = 3,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_one_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [ERR_W-1:0]  push_err_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic [ERR_W-1:0]  head_err_o,
  output logic [CW-1:0]     level_o,
  output logic              push_ok_o,
  output logic              pop_ok_o,
  output logic              drop_o
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [ERR_W-1:0]  err_q  [DEPTH];
  logic [AW-1:0]     rd_ptr_q, wr_ptr_q;
  logic [CW-1:0]     level_q;
  logic              full, empty;

  assign empty     = (level_q == '0);
  assign full      = cap_one_i ? (level_q != '0) : (level_q == FULL_LVL);
  assign pop_ok_o  = pop_i && !empty && !clr_i;
  assign push_ok_o = push_i && !clr_i && (!full || pop_ok_o);
  assign drop_o    = push_i && !clr_i && full && !pop_ok_o;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) begin
      data_q[wr_ptr_q] <= push_data_i;
      err_q[wr_ptr_q]  <= push_err_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      level_q  <= '0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok_o)  rd_ptr_q <= rd_ptr_q + 1'b1;
      unique case ({push_ok_o, pop_ok_o})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign head_data_o = empty ? '0 : data_q[rd_ptr_q];
  assign head_err_o  = empty ? '0 : err_q[rd_ptr_q];
  assign level_o     = level_q;
endmodule

// File: rtl/rx_err_track.sv
module rx_err_track #(
  parameter int unsigned CW = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  input  logic drop_i,
  input  logic lsr_rd_i,
  output logic err_any_o,
  output logic overrun_o
);
  logic [CW-1:0] err_cnt_q;
  logic          ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_cnt_q <= '0;
    end else if (clr_i) begin
      err_cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   err_cnt_q <= err_cnt_q + 1'b1;
        2'b01:   err_cnt_q <= err_cnt_q - 1'b1;
        default: err_cnt_q <= err_cnt_q;
      endcase
    end
  end

  // a drop in the same cycle as the read survives it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ovr_q <= 1'b0;
    else if (drop_i)   ovr_q <= 1'b1;
    else if (lsr_rd_i) ovr_q <= 1'b0;
  end

  assign err_any_o = (err_cnt_q != '0);
  assign overrun_o = ovr_q;
endmodule

// File: rtl/rx_lsi_arm.sv
module rx_lsi_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic new_head_i,
  input  logic lsr_rd_i,
  input  logic head_err_i,
  input  logic en_i,
  output logic lsi_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  armed_q <= 1'b1;
    else if (clr_i || new_head_i) armed_q <= 1'b1;
    else if (lsr_rd_i)            armed_q <= 1'b0;
  end

  assign lsi_o = en_i && armed_q && head_err_i;
endmodule

// File: rtl/rx_trig_sel.sv
module rx_trig_sel #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] level_i,
  input  logic [1:0]    sel_i,
  input  logic          fifo_en_i,
  output logic          trig_o
);
  localparam logic [CW-1:0] THR0 = CW'(1);
  localparam logic [CW-1:0] THR1 = CW'(DEPTH / 4);
  localparam logic [CW-1:0] THR2 = CW'(DEPTH / 2);
  localparam logic [CW-1:0] THR3 = CW'(DEPTH - 2);

  logic [CW-1:0] thr;

  always_comb begin
    unique case (sel_i)
      2'd0:    thr = THR0;
      2'd1:    thr = THR1;
      2'd2:    thr = THR2;
      default: thr = THR3;
    endcase
  end

  assign trig_o = fifo_en_i ? (level_i >= thr) : (level_i != '0);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_fifo_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [ERR_W-1:0]  push_err_i,
  input  logic              pop_i,
  input  logic              lsr_rd_i,
  input  logic              lsi_en_i,
  input  logic [1:0]        trig_sel_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic [ERR_W-1:0]  head_err_o,
  output logic [CW-1:0]     level_o,
  output logic              trig_o,
  output logic              err_any_o,
  output logic              overrun_o,
  output logic              lsi_o
);
  logic fifo_en_q, clr;
  logic push_ok, pop_ok, drop;
  logic head_bad, new_head;

  // any mode change restarts the queue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_en_q <= 1'b0;
    else         fifo_en_q <= fifo_en_i;
  end
  assign clr = flush_i || (fifo_en_i != fifo_en_q);

  rx_fifo_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .ERR_W (ERR_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .cap_one_i  (!fifo_en_i),
    .push_i     (push_i),
    .push_data_i(push_data_i),
    .push_err_i (push_err_i),
    .pop_i      (pop_i),
    .head_data_o(head_data_o),
    .head_err_o (head_err_o),
    .level_o    (level_o),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .drop_o     (drop)
  );

  assign head_bad = |head_err_o;
  assign new_head = pop_ok || (push_ok && level_o == '0);

  rx_err_track #(.CW(CW)) i_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .inc_i    (push_ok && (|push_err_i)),
    .dec_i    (pop_ok && head_bad),
    .drop_i   (drop),
    .lsr_rd_i (lsr_rd_i),
    .err_any_o(err_any_o),
    .overrun_o(overrun_o)
  );

  rx_lsi_arm i_lsi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .new_head_i(new_head),
    .lsr_rd_i  (lsr_rd_i),
    .head_err_i(head_bad),
    .en_i      (lsi_en_i),
    .lsi_o     (lsi_o)
  );

  rx_trig_sel #(.DEPTH(DEPTH)) i_trig (
    .level_i  (level_o),
    .sel_i    (trig_sel_i),
    .fifo_en_i(fifo_en_i),
    .trig_o   (trig_o)
  );
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_en_i,
  input logic              flush_i,
  input logic              pop_i,
  input logic              lsr_rd_i,
  input logic              lsi_en_i,
  input logic [DATA_W-1:0] head_data_o,
  input logic [2:0]        head_err_o,
  input logic [CW-1:0]     level_o,
  input logic              err_any_o,
  input logic              overrun_o,
  input logic              lsi_o
);
  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) |-> (head_data_o == '0 && head_err_o == '0)); // R2
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= CW'(DEPTH)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !lsr_rd_i) |=> overrun_o); // R3
  AST_LSI_NEEDS_HEAD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsi_o |-> (lsi_en_i && head_err_o != '0)); // R4
  AST_LSR_CLEARS_LSI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !pop_i && level_o != '0) |=> !lsi_o); // R5
  AST_HEAD_ERR_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_err_o != '0) |-> err_any_o); // R7
  AST_SINGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !$past(fifo_en_i)) |-> (level_o <= CW'(1))); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0 && !err_any_o && !lsi_o)); // R10
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_en_i  (fifo_en_i),
  .flush_i    (flush_i),
  .pop_i      (pop_i),
  .lsr_rd_i   (lsr_rd_i),
  .lsi_en_i   (lsi_en_i),
  .head_data_o(head_data_o),
  .head_err_o (head_err_o),
  .level_o    (level_o),
  .err_any_o  (err_any_o),
  .overrun_o  (overrun_o),
  .lsi_o      (lsi_o)
);

// File: tb/test_rx_err_fifo.sv
`timescale 1ns/1ps
module test_rx_err_fifo;
  localparam int NV = 16;
  // {push, data, err, pop, lsr | level, head data, head err, err_any, lsi}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 8'hA1, 3'b000, 1'b0, 1'b0, 5'd1, 8'hA1, 3'b000, 1'b0, 1'b0},
    {1'b1, 8'hB2, 3'b001, 1'b0, 1'b0, 5'd2, 8'hA1, 3'b000, 1'b1, 1'b0},
    {1'b1, 8'hC3, 3'b000, 1'b0, 1'b0, 5'd3, 8'hA1, 3'b000, 1'b1, 1'b0},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 5'd2, 8'hB2, 3'b001, 1'b1, 1'b1},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 5'd2, 8'hB2, 3'b001, 1'b1, 1'b0},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b0, 5'd2, 8'hB2, 3'b001, 1'b1, 1'b0},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 5'd1, 8'hC3, 3'b000, 1'b0, 1'b0},
    {1'b1, 8'hD4, 3'b010, 1'b0, 1'b0, 5'd2, 8'hC3, 3'b000, 1'b1, 1'b0},
    {1'b1, 8'hE5, 3'b100, 1'b0, 1'b0, 5'd3, 8'hC3, 3'b000, 1'b1, 1'b0},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 5'd2, 8'hD4, 3'b010, 1'b1, 1'b1},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 5'd1, 8'hE5, 3'b100, 1'b1, 1'b1},
    {1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 5'd1, 8'hE5, 3'b100, 1'b1, 1'b0},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 5'd0, 8'h00, 3'b000, 1'b0, 1'b0},
    {1'b1, 8'hF6, 3'b001, 1'b0, 1'b0, 5'd1, 8'hF6, 3'b001, 1'b1, 1'b1},
    {1'b1, 8'h17, 3'b000, 1'b1, 1'b0, 5'd1, 8'h17, 3'b000, 1'b0, 1'b0},
    {1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 5'd0, 8'h00, 3'b000, 1'b0, 1'b0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b1, flush_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic       lsr_rd_i = 1'b0, lsi_en_i = 1'b1;
  logic [7:0] push_data_i = '0;
  logic [2:0] push_err_i = '0;
  logic [1:0] trig_sel_i = '0;
  logic [7:0] head_data_o;
  logic [2:0] head_err_o;
  logic [4:0] level_o;
  logic       trig_o, err_any_o, overrun_o, lsi_o;
  int         n_chk = 0, n_err = 0;
  logic       done = 1'b0;

  always #2 clk_i = ~clk_i;

  rx_err_fifo i_rx_err_fifo (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
    push_i = 1'b0; pop_i = 1'b0; lsr_rd_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    push_i = 1'b1; push_data_i = d; push_err_i = e;
    tick();
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] exp_v;
    int thr [4];
    thr[0] = 1; thr[1] = 4; thr[2] = 8; thr[3] = 14;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    // R1 reset state
    check("R1 level", 32'(level_o), 0);
    check("R1 head", {head_data_o, head_err_o}, 0);
    check("R1 flags", {err_any_o, overrun_o, lsi_o}, 0);

    // R2 R4 R5 R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      push_i = VEC[i][31]; push_data_i = VEC[i][30:23]; push_err_i = VEC[i][22:20];
      pop_i = VEC[i][19]; lsr_rd_i = VEC[i][18];
      tick();
      exp_v = {14'd0, VEC[i][17:0]};
      check($sformatf("R2/R4/R5/R6/R7 vector %0d", i),
            {14'd0, level_o, head_data_o, head_err_o, err_any_o, lsi_o}, exp_v);
    end

    // R8 trigger thresholds while filling, then R3 full behaviour
    for (int k = 1; k <= 16; k++) begin
      push(8'(k), 3'b000);
      for (int s = 0; s < 4; s++) begin
        trig_sel_i = 2'(s);
        #1;
        check($sformatf("R8 level %0d sel %0d", k, s), 32'(trig_o), 32'(k >= thr[s]));
      end
    end
    check("R3 full level", 32'(level_o), 16);
    check("R3 no overrun yet", 32'(overrun_o), 0);
    push(8'hEE, 3'b001);
    check("R3 drop level", 32'(level_o), 16);
    check("R3 drop head", 32'(head_data_o), 32'h01);
    check("R3 overrun set", 32'(overrun_o), 1);
    check("R3 dropped error not counted", 32'(err_any_o), 0);
    pop_i = 1'b1;
    push(8'h99, 3'b000);
    check("R3 push with pop at full", {level_o, head_data_o}, {5'd16, 8'h02});
    tick();
    check("R3 overrun sticky", 32'(overrun_o), 1);
    lsr_rd_i = 1'b1;
    tick();
    check("R3 overrun cleared by read", 32'(overrun_o), 0);

    // R4 interrupt enable gating
    flush_i = 1'b1;
    tick();
    check("R10 flush level", 32'(level_o), 0);
    lsi_en_i = 1'b0;
    push(8'h3C, 3'b010);
    check("R4 disabled interrupt", 32'(lsi_o), 0);
    check("R7 err any", 32'(err_any_o), 1);
    lsi_en_i = 1'b1;
    #1;
    check("R4 enabled interrupt", 32'(lsi_o), 1);
    flush_i = 1'b1;
    tick();
    check("R10 flush clears", {level_o, err_any_o, lsi_o}, 0);

    // R9 single holding byte
    fifo_en_i = 1'b0;
    tick();
    push(8'h55, 3'b001);
    check("R9 hold one", {level_o, head_data_o, head_err_o}, {5'd1, 8'h55, 3'b001});
    check("R9 interrupt from holding byte", 32'(lsi_o), 1);
    trig_sel_i = 2'd3;
    #1;
    check("R9 trigger at one", 32'(trig_o), 1);
    push(8'h66, 3'b000);
    check("R9 second push dropped", {level_o, head_data_o}, {5'd1, 8'h55});
    check("R9 overrun", 32'(overrun_o), 1);

    // R10 mode change empties and keeps overrun
    fifo_en_i = 1'b1;
    tick();
    check("R10 mode change empties", {level_o, err_any_o, lsi_o}, 0);
    check("R10 overrun kept", 32'(overrun_o), 1);
    check("R8 trigger low when empty", 32'(trig_o), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule